// File: doc/BRIEF.md
# Synchronous Byte-Lane SRAM Core

This block is a single-port clocked memory with one bidirectional data bus, split into byte lanes of nine bits each (four lanes, 36 bits, by default). Each rising clock edge samples a command made of an active-low select, an active-low write strobe, an address and one active-low write mask bit per lane. A read command presents the addressed word on the bus during the cycle after its sampling edge. A write command expects its data on the bus in the cycle after its sampling edge, and stores that data on the next edge. Only the lanes whose mask bit was low when the command was sampled are stored.

Whether the bus is driven depends on two things. The registered control logic must allow it, and an asynchronous active-low output enable must also allow it. The control logic keeps the drivers off in three cases: while the bus carries write data, while the part is deselected, and during the turnaround cycle after it becomes selected again. An active-high sleep input makes the core ignore every command and turns its drivers off at once. The stored contents are kept.

A read sampled on the same edge that commits a write to the same address returns the newly written lanes, merged with the stored lanes that were not written.

Top module: `bwsram_core`

## Requirements
- R1: After reset the core does not drive the data bus, even with output enable low.
- R2: A read sampled at an edge places the word stored at the sampled address on the bus during the following cycle, when output enable is low and the read is driven (see R7).
- R3: A write sampled at edge N takes its data from the bus at edge N+1. Lane i is bus bits [9i+8:9i] and is updated only if mask bit i was low at edge N. All other lanes keep their contents.
- R4: Output enable high turns the bus drivers off at once, with no clock edge needed. Setting it low again re-enables the driven word.
- R5: The core never drives the bus in the cycle after a sampled write command, which is the write data phase.
- R6: The core does not drive the bus in the cycle after an edge that sampled select high.
- R7: A read sampled at the first selected edge after a deselected edge, after reset or after sleep is not driven onto the bus. A read that follows a selected edge is driven.
- R8: Sleep high turns the drivers off at once. Commands sampled while sleep is high are ignored, and the contents are preserved across sleep.
- R9: A write whose data-phase edge sees sleep high is dropped and leaves memory unchanged.
- R10: A read sampled at the data-phase edge of a write to the same address returns the written lanes merged with the unwritten stored lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the control state |
| sel_n | input | 1 | Active-low select, sampled |
| wr_n | input | 1 | Active-low write strobe, sampled; high selects read |
| lane_wr_n | input | 4 | Active-low per-lane write mask, bit i for lane i |
| addr | input | 6 | Word address, sampled |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Active-high sleep |
| dq | inout | 36 | Bidirectional data bus |

## Verification
The assertions check the bus-drive rules on every cycle: drivers off while output enable or sleep is high, and drivers off in the cycle after a write command, a deselected edge or a re-selecting read. The data itself can be checked only by the bench's scenarios. These are the full address sweep, the sixteen lane-mask patterns, the forwarding of a same-address read, and the preservation of contents across sleep, including a write dropped at its data-phase edge.

// File: rtl/bwsram_pkg.sv
package bwsram_pkg;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2
    } cmd_e;

endpackage

// File: rtl/bwsram_ctrl.sv
module bwsram_ctrl
    import bwsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sleep,
    output cmd_e              cmd,
    output logic              commit,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [LANES-1:0]  commit_mask,
    output logic              drive_q
);

    typedef struct packed {
        logic              wr_pend;
        logic [ADDR_W-1:0] wr_addr;
        logic [LANES-1:0]  wr_mask;
        logic              rd_drive;
        logic              was_sel;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  selected;

    always_comb begin
        selected = !sel_n && !sleep;
        if (!selected)  cmd = CMD_NONE;
        else if (!wr_n) cmd = CMD_WRITE;
        else            cmd = CMD_READ;

        st_d          = st_q;
        st_d.wr_pend  = (cmd == CMD_WRITE);
        st_d.wr_addr  = addr;
        st_d.wr_mask  = ~lane_wr_n;
        st_d.rd_drive = (cmd == CMD_READ) && st_q.was_sel;
        st_d.was_sel  = selected;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign commit      = st_q.wr_pend && !sleep;
    assign commit_addr = st_q.wr_addr;
    assign commit_mask = st_q.wr_mask;
    assign drive_q     = st_q.rd_drive;

    // R7: a read is never armed for driving unless the prior edge was selected
    p_turnaround_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_READ && !st_q.was_sel) |=> !st_q.rd_drive);

    // R9: sleep at the data-phase edge blocks the commit
    p_sleep_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !commit);

endmodule

// File: rtl/bwsram_array.sv
module bwsram_array
    import bwsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  cmd_e                    cmd,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic                    commit,
    input  logic [ADDR_W-1:0]       commit_addr,
    input  logic [LANES-1:0]        commit_mask,
    input  logic [LANES*LANE_W-1:0] wr_data,
    output logic [LANES*LANE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic same_word;
    assign same_word = commit && (commit_addr == rd_addr);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];
        logic [LANE_W-1:0] lane_in;
        logic [LANE_W-1:0] out_d, out_q;
        logic              fwd;

        assign lane_in = wr_data[l*LANE_W +: LANE_W];
        assign fwd     = same_word && commit_mask[l];

        always_comb begin
            out_d = out_q;
            if (cmd == CMD_READ) begin
                out_d = fwd ? lane_in : store[rd_addr];
            end
        end

        always_ff @(posedge clk) begin
            out_q <= out_d;
            if (commit && commit_mask[l]) begin
                store[commit_addr] <= lane_in;
            end
        end

        assign rd_data[l*LANE_W +: LANE_W] = out_q;
    end

endmodule

// File: rtl/bwsram_drive.sv
module bwsram_drive #(
    parameter int WIDTH = 36
) (
    input  logic             drive_q,
    input  logic             out_en_n,
    input  logic             sleep,
    input  logic [WIDTH-1:0] rd_data,
    output logic             bus_oe,
    inout  wire  [WIDTH-1:0] dq
);

    assign bus_oe = drive_q && !out_en_n && !sleep;
    assign dq     = bus_oe ? rd_data : {WIDTH{1'bz}};

    // R4 / R8: asynchronous gates override the registered permission
    always_comb begin
        a_gate_r4: assert (!(bus_oe && (out_en_n || sleep)));
    end

endmodule

// File: rtl/bwsram_core.sv
module bwsram_core
    import bwsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel_n,
    input  logic                    wr_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    out_en_n,
    input  logic                    sleep,
    inout  wire  [LANES*LANE_W-1:0] dq
);

    localparam int WIDTH = LANES * LANE_W;

    cmd_e              cmd;
    logic              commit;
    logic [ADDR_W-1:0] commit_addr;
    logic [LANES-1:0]  commit_mask;
    logic              drive_q;
    logic [WIDTH-1:0]  rd_data;
    logic              bus_oe;

    bwsram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n),
        .lane_wr_n(lane_wr_n), .addr(addr), .sleep(sleep),
        .cmd(cmd), .commit(commit), .commit_addr(commit_addr),
        .commit_mask(commit_mask), .drive_q(drive_q)
    );

    bwsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) array_i (
        .clk(clk), .cmd(cmd), .rd_addr(addr), .commit(commit),
        .commit_addr(commit_addr), .commit_mask(commit_mask),
        .wr_data(dq), .rd_data(rd_data)
    );

    bwsram_drive #(.WIDTH(WIDTH)) drive_i (
        .drive_q(drive_q), .out_en_n(out_en_n), .sleep(sleep),
        .rd_data(rd_data), .bus_oe(bus_oe), .dq(dq)
    );

    p_wr_phase_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !wr_n && !sleep) |=> !bus_oe);

    p_desel_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> !bus_oe);

    p_oe_high_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !bus_oe);

    p_sleep_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !bus_oe);

endmodule

// File: tb/bwsram_core_tb.sv
`timescale 1ns/1ps
module bwsram_core_tb_top;

    localparam int AW = 6;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int W  = NL * LW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_n = 1'b1;
    logic          wr_n = 1'b1;
    logic [NL-1:0] lane_wr_n = '1;
    logic [AW-1:0] addr = '0;
    logic          out_en_n = 1'b0;
    logic          sleep = 1'b0;
    logic          tb_en = 1'b0;
    logic [W-1:0]  tb_data = '0;
    wire  [W-1:0]  dq;

    logic [W-1:0]  ref_mem [DEPTH];
    int            total = 0;
    int            bad = 0;
    bit            done = 1'b0;

    always #2 clk = ~clk;

    assign dq = tb_en ? tb_data : {W{1'bz}};

    bwsram_core #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n),
        .lane_wr_n(lane_wr_n), .addr(addr), .out_en_n(out_en_n),
        .sleep(sleep), .dq(dq)
    );

    function automatic logic [W-1:0] pat(input int a, input int s);
        logic [W-1:0] v;
        v = W'(a) * 36'h9E37 + W'(s) * 36'h1234567;
        return v ^ 36'h5A5A5A5A5;
    endfunction

    task automatic check(input logic [W-1:0] exp, input string req);
        total++;
        if (dq !== exp) begin
            bad++;
            $display("FAIL %s: dq=%h expected=%h", req, dq, exp);
        end
    endtask

    // Set inputs at the negedge, pass one rising edge, return at the next negedge.
    task automatic cycle(input logic s_n, input logic w_n, input logic [NL-1:0] m_n,
                         input int a, input logic den, input logic [W-1:0] d);
        sel_n = s_n; wr_n = w_n; lane_wr_n = m_n; addr = AW'(a);
        tb_en = den; tb_data = d;
        @(posedge clk);
        #1 tb_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic desel(input logic den, input logic [W-1:0] d);
        cycle(1'b1, 1'b1, '1, 0, den, d);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        total++; bad++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [W-1:0] prev_d;
        logic [W-1:0] nd;
        logic [W-1:0] zz;
        zz = {W{1'bz}};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(zz, "R1 idle after reset");

        // R3 fill all words back to back, data trailing by one cycle
        prev_d = '0;
        for (int a = 0; a < DEPTH; a++) begin
            cycle(1'b0, 1'b0, '0, a, a != 0, prev_d);
            if (a == 0) check(zz, "R5 write data phase undriven");
            prev_d = pat(a, 1);
            ref_mem[a] = prev_d;
        end
        desel(1'b1, prev_d);
        check(zz, "R6 deselected");

        // R7 first read after deselect is a turnaround, then R2 sweep
        cycle(1'b0, 1'b1, '1, 0, 1'b0, '0);
        check(zz, "R7 turnaround read undriven");
        for (int a = 0; a < DEPTH; a++) begin
            cycle(1'b0, 1'b1, '1, a, 1'b0, '0);
            check(ref_mem[a], "R2 read sweep");
        end

        // R4 asynchronous output enable
        #1 out_en_n = 1'b1;
        #0.5 check(zz, "R4 oe high");
        out_en_n = 1'b0;
        #0.5 check(ref_mem[DEPTH-1], "R4 oe low again");
        @(negedge clk);

        // R3 lane masks: every pattern on its own word
        desel(1'b0, '0);
        for (int m = 0; m < 16; m++) begin
            nd = pat(m, 7);
            cycle(1'b0, 1'b0, ~NL'(m), m, 1'b0, '0);
            check(zz, "R5 write data phase undriven");
            desel(1'b1, nd);
            for (int l = 0; l < NL; l++)
                if (m[l]) ref_mem[m][l*LW +: LW] = nd[l*LW +: LW];
        end
        cycle(1'b0, 1'b1, '1, 0, 1'b0, '0);
        for (int m = 0; m < 16; m++) begin
            cycle(1'b0, 1'b1, '1, m, 1'b0, '0);
            check(ref_mem[m], "R3 lane mask readback");
        end

        // R10 same-address read at the data-phase edge, partial mask
        nd = pat(40, 9);
        cycle(1'b0, 1'b0, 4'b1010, 40, 1'b0, '0);
        cycle(1'b0, 1'b1, '1, 40, 1'b1, nd);
        ref_mem[40][0 +: LW]    = nd[0 +: LW];
        ref_mem[40][2*LW +: LW] = nd[2*LW +: LW];
        check(ref_mem[40], "R10 forwarded merge");
        cycle(1'b0, 1'b1, '1, 40, 1'b0, '0);
        check(ref_mem[40], "R10 stored after forward");

        // R8 sleep: drivers off at once, commands ignored
        #1 sleep = 1'b1;
        #0.5 check(zz, "R8 sleep drivers off");
        @(negedge clk);
        cycle(1'b0, 1'b0, '0, 7, 1'b0, '0);
        cycle(1'b0, 1'b1, '1, 7, 1'b1, pat(99, 3));
        check(zz, "R8 read during sleep undriven");
        sleep = 1'b0;
        cycle(1'b0, 1'b1, '1, 7, 1'b0, '0);
        check(zz, "R7 turnaround after sleep");
        cycle(1'b0, 1'b1, '1, 7, 1'b0, '0);
        check(ref_mem[7], "R8 contents preserved");

        // R9 write whose data edge sees sleep is dropped
        cycle(1'b0, 1'b0, '0, 9, 1'b0, '0);
        sleep = 1'b1;
        desel(1'b1, pat(77, 5));
        sleep = 1'b0;
        desel(1'b0, '0);
        cycle(1'b0, 1'b1, '1, 9, 1'b0, '0);
        cycle(1'b0, 1'b1, '1, 9, 1'b0, '0);
        check(ref_mem[9], "R9 dropped write");

        desel(1'b0, '0);
        check(zz, "R6 deselected at end");
        finish_run();
    end

endmodule